// File: doc/BRIEF.md
# Double-Buffered Compare Timer

A peripheral timer with one counter and up to seven compare channels. Software writes a compare register in each channel. The value the comparator actually uses is a hidden shadow latch. A two-bit load mode per channel decides when that latch takes the register value: at once, when the count passes zero, at zero or on its own match in up/down counting, or only on its own match. Because of this, software can reprogram a period or a duty point at any time without glitching the cycle that is in progress.

The counter advances once per cycle in which `tick` is high. It can be stopped, count up to a period, run freely over a selectable length, or count up and down between zero and a period. Channel 0's latch sets the period in the up and up/down modes. Each channel has a sticky match flag, and the counter has a sticky overflow flag. Two interrupt lines combine the flags with their enables.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: Reset clears the counter, every compare register, every channel control field and every latch. It also clears the run mode, the length, the enables and all flags, so every readable address returns 0 and both interrupts are low.
- R2: Load mode 0 copies a written compare value into that channel's latch in the same write. The new value is compared from the next tick onwards.
- R3: Load mode 1 copies the compare register into the latch on a tick taken while the counter is 0 and the timer is not stopped. At any other time the latch keeps its value.
- R4: Load mode 2 loads at a counter value of 0 as in R3. In up/down mode it also loads on a tick where the counter equals the channel's current latch.
- R5: Load mode 3 loads on every tick where the counter equals the channel's current latch.
- R6: Up mode counts 0,1,… up to latch 0. On the tick taken at latch 0 it goes to 0 and sets the overflow flag. It also wraps at the end of the selected length.
- R7: Up/down mode turns to counting down on the tick taken at or above latch 0, and turns up on the tick taken at 0. The overflow flag is set on the tick that moves the counter from 1 down to 0.
- R8: Continuous mode wraps to 0 and sets the overflow flag after the length limit. The length field 0/1/2/3 selects 16/12/10/8 bits, so with 8 bits a counter at 0xFE reaches 0 two ticks later.
- R9: On every tick in a running mode, a channel whose latch equals the counter value before it advances sets its match flag. In stop mode (mode 0), ticks change neither the counter, the flags nor the latches.
- R10: A flag is cleared only by writing 0 to its bit. Writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R11: `irq0` is high while channel 0's flag and enable are both set. `irq1` is high while any other channel has its flag and enable set, or while the overflow flag and its enable are set.
- R12: Register map: address 0 is control, with bits [1:0] the run mode (0 stop, 1 up, 2 continuous, 3 up/down), [3:2] the length, [4] the overflow enable and [5] the overflow flag. Address 1 is the counter, which is writable, and a write there takes priority over a tick. Channel k uses address 2+2k for control, with bits [1:0] the load mode, [2] the enable and [3] the flag, and address 3+2k for the compare register, which reads back the register and not the latch. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one counter step per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | CNT_W | Write data |
| rdAddr | input | ADDR_W | Read address (combinational read) |
| rdData | output | CNT_W | Read data |
| irq0 | output | 1 | Channel 0 interrupt |
| irq1 | output | 1 | Other channels and overflow interrupt |

## Verification
A latch holding the wrong value cannot be read directly. It shows up as a match flag and an interrupt that fire one counter lap early or late, or, for channel 0, as a period or turn-around point that moves. These effects appear within one counter period of the wrong load. The bench therefore compares every readable address and both interrupt lines against a behavioural model on each clock, so a misplaced load is reported on the first tick where the counter reaches either the correct latch value or the wrong one. Directed cases pin the moments the load modes differ: writes made just before zero, just before a match, and at the up/down turn-around.

// File: rtl/dbuf_timer_pkg.sv
package dbuf_timer_pkg;

  typedef enum logic [1:0] {
    RUN_STOP = 2'd0,
    RUN_UP   = 2'd1,
    RUN_CONT = 2'd2,
    RUN_UPDN = 2'd3
  } runMode_e;

  typedef enum logic [1:0] {
    LD_NOW       = 2'd0,
    LD_ZERO      = 2'd1,
    LD_ZERO_TURN = 2'd2,
    LD_MATCH     = 2'd3
  } loadMode_e;

  // strobes handed from the counter control to the channel datapath
  typedef struct packed {
    logic run;     // tick taken in a running mode
    logic atZero;  // counter is zero before this step
    logic upDown;  // up/down mode active
  } timerStrobe_t;

  localparam int CTL_BITS  = 6;
  localparam int CHAN_BITS = 4;

endpackage

// File: rtl/dbuf_timer_ctrl.sv
module dbuf_timer_ctrl
  import dbuf_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                ctlWr,
  input  logic                cntWr,
  input  logic [CNT_W-1:0]    wrData,
  input  logic [CNT_W-1:0]    latch0,
  output logic [CNT_W-1:0]    count,
  output logic [CTL_BITS-1:0] ctlWord,
  output logic                ovfIrq,
  output timerStrobe_t        strb
);

  localparam logic [CNT_W-1:0] LIM12 = CNT_W'(4095);
  localparam logic [CNT_W-1:0] LIM10 = CNT_W'(1023);
  localparam logic [CNT_W-1:0] LIM8  = CNT_W'(255);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  runMode_e         mode;
  logic [1:0]       lenSel;
  logic             ovfIe;
  logic             ovfFlag;
  logic             goDown;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cntNext;
  logic             dirNext;
  logic             ovfHit;
  logic             run;

  assign run = tick && (mode != RUN_STOP);

  always_comb begin
    case (lenSel)
      2'd0:    limit = '1;
      2'd1:    limit = LIM12;
      2'd2:    limit = LIM10;
      default: limit = LIM8;
    endcase
  end

  always_comb begin
    cntNext = count;
    dirNext = goDown;
    ovfHit  = 1'b0;
    if (run) begin
      case (mode)
        RUN_UP: begin
          if (count == latch0 || count >= limit) begin
            cntNext = '0;
            ovfHit  = 1'b1;
          end else begin
            cntNext = count + ONE;
          end
        end
        RUN_CONT: begin
          if (count >= limit) begin
            cntNext = '0;
            ovfHit  = 1'b1;
          end else begin
            cntNext = count + ONE;
          end
        end
        RUN_UPDN: begin
          if (count >= latch0 || count >= limit) dirNext = 1'b1;
          if (count == '0) dirNext = 1'b0;
          if (dirNext) begin
            cntNext = count - ONE;
            ovfHit  = (count == ONE);
          end else begin
            cntNext = count + ONE;
          end
        end
        default: cntNext = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      goDown  <= 1'b0;
      mode    <= RUN_STOP;
      lenSel  <= 2'd0;
      ovfIe   <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      count  <= cntWr ? wrData : cntNext;
      goDown <= dirNext;
      if (ctlWr) begin
        mode   <= runMode_e'(wrData[1:0]);
        lenSel <= wrData[3:2];
        ovfIe  <= wrData[4];
      end
      ovfFlag <= (ctlWr ? (ovfFlag & wrData[5]) : ovfFlag) | ovfHit;
    end
  end

  assign ctlWord     = {ovfFlag, ovfIe, lenSel, mode};
  assign ovfIrq      = ovfFlag & ovfIe;
  assign strb.run    = run;
  assign strb.atZero = (count == '0);
  assign strb.upDown = (mode == RUN_UPDN);

endmodule

// File: rtl/dbuf_timer_chan.sv
module dbuf_timer_chan
  import dbuf_timer_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  timerStrobe_t                         strb,
  input  logic [CNT_W-1:0]                     count,
  input  logic                                 wrEn,
  input  logic [ADDR_W-1:0]                    wrAddr,
  input  logic [CNT_W-1:0]                     wrData,
  output logic [NUM_CH-1:0][CHAN_BITS-1:0]     chanCtl,
  output logic [NUM_CH-1:0][CNT_W-1:0]         chanCmp,
  output logic [NUM_CH-1:0]                    chanIrq,
  output logic [CNT_W-1:0]                     latch0
);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int CTL_A = 2 + 2 * k;
    localparam int CMP_A = 3 + 2 * k;

    logic             ctlHit;
    logic             cmpHit;
    logic             match;
    logic             loadEvt;
    loadMode_e        ldMode;
    logic             irqEn;
    logic             flagQ;
    logic [CNT_W-1:0] cmpQ;
    logic [CNT_W-1:0] latQ;

    assign ctlHit = wrEn && (wrAddr == ADDR_W'(CTL_A));
    assign cmpHit = wrEn && (wrAddr == ADDR_W'(CMP_A));
    assign match  = strb.run && (count == latQ);

    always_comb begin
      case (ldMode)
        LD_NOW:       loadEvt = 1'b0;
        LD_ZERO:      loadEvt = strb.run && strb.atZero;
        LD_ZERO_TURN: loadEvt = strb.run && (strb.atZero || (strb.upDown && count == latQ));
        LD_MATCH:     loadEvt = match;
        default:      loadEvt = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpQ   <= '0;
        latQ   <= '0;
        ldMode <= LD_NOW;
        irqEn  <= 1'b0;
        flagQ  <= 1'b0;
      end else begin
        if (cmpHit) cmpQ <= wrData;
        if (cmpHit && ldMode == LD_NOW) latQ <= wrData;
        else if (loadEvt)               latQ <= cmpQ;
        if (ctlHit) begin
          ldMode <= loadMode_e'(wrData[1:0]);
          irqEn  <= wrData[2];
        end
        flagQ <= (ctlHit ? (flagQ & wrData[3]) : flagQ) | match;
      end
    end

    assign chanCtl[k] = {flagQ, irqEn, ldMode};
    assign chanCmp[k] = cmpQ;
    assign chanIrq[k] = flagQ & irqEn;

    if (k == 0) begin : g_period
      assign latch0 = latQ;
    end
  end

endmodule

// File: rtl/dbuf_cmp_timer.sv
module dbuf_cmp_timer
  import dbuf_timer_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = $clog2(2 + 2 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq0,
  output logic              irq1
);

  timerStrobe_t                       strb;
  logic [CNT_W-1:0]                   cntVal;
  logic [CNT_W-1:0]                   latch0;
  logic [CTL_BITS-1:0]                ctlWord;
  logic                               ovfIrq;
  logic [NUM_CH-1:0][CHAN_BITS-1:0]   chanCtl;
  logic [NUM_CH-1:0][CNT_W-1:0]       chanCmp;
  logic [NUM_CH-1:0]                  chanIrq;
  logic                               ctlWr;
  logic                               cntWr;

  assign ctlWr = wrEn && (wrAddr == ADDR_W'(0));
  assign cntWr = wrEn && (wrAddr == ADDR_W'(1));

  dbuf_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .ctlWr   (ctlWr),
    .cntWr   (cntWr),
    .wrData  (wrData),
    .latch0  (latch0),
    .count   (cntVal),
    .ctlWord (ctlWord),
    .ovfIrq  (ovfIrq),
    .strb    (strb)
  );

  dbuf_timer_chan #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chan (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .count   (cntVal),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .chanCtl (chanCtl),
    .chanCmp (chanCmp),
    .chanIrq (chanIrq),
    .latch0  (latch0)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(0)) rdData = CNT_W'(ctlWord);
    if (rdAddr == ADDR_W'(1)) rdData = cntVal;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rdAddr == ADDR_W'(2 + 2 * k)) rdData = CNT_W'(chanCtl[k]);
      if (rdAddr == ADDR_W'(3 + 2 * k)) rdData = chanCmp[k];
    end
  end

  always_comb begin
    irq1 = ovfIrq;
    for (int k = 1; k < NUM_CH; k++) irq1 = irq1 | chanIrq[k];
  end

  assign irq0 = chanIrq[0];

endmodule

// File: rtl/dbuf_timer_chk.sv
module dbuf_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             irq0,
  input logic             runStb,
  input logic             flag0,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] latch0,
  input logic [5:0]       ctlWord
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rstN |=> (cntVal == '0 && latch0 == '0 && ctlWord == '0));

  assert_latch_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runStb && !wrEn) |=> $stable(latch0));

  assert_up_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (runStb && ctlWord[1:0] == 2'd1 && cntVal == latch0 && !wrEn)
      |=> (cntVal == '0 && ctlWord[5]));

  assert_cont_wrap8_R8: assert property (@(posedge clk) disable iff (!rstN)
    (runStb && ctlWord[1:0] == 2'd2 && ctlWord[3:2] == 2'd3 &&
     cntVal == CNT_W'(255) && !wrEn) |=> (cntVal == '0));

  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWord[1:0] == 2'd0 && !wrEn) |=> $stable(cntVal));

  assert_match_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (runStb && cntVal == latch0) |=> flag0);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flag0 && !wrEn) |=> flag0);

  assert_irq0_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq0) |-> $past(runStb || wrEn));

endmodule

bind dbuf_cmp_timer dbuf_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .irq0    (irq0),
  .runStb  (strb.run),
  .flag0   (chanCtl[0][3]),
  .cntVal  (cntVal),
  .latch0  (latch0),
  .ctlWord (ctlWord)
);

// File: tb/dbuf_cmp_timer_tb.sv
module dbuf_cmp_timer_tb;

  localparam int NCH = 7;
  localparam int CW  = 16;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic [CW-1:0] rdData;
  logic          irq0;
  logic          irq1;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dbuf_cmp_timer #(.NUM_CH(NCH), .CNT_W(CW)) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .irq0   (irq0),
    .irq1   (irq1)
  );

  // behavioural reference model
  logic [CW-1:0] mCnt;
  bit            mDown;
  logic [1:0]    mMode, mLen;
  bit            mOvfIe, mOvf;
  logic [CW-1:0] mCmp [NCH];
  logic [CW-1:0] mLat [NCH];
  logic [1:0]    mLd  [NCH];
  bit            mIe  [NCH];
  bit            mFlg [NCH];

  function automatic logic [CW-1:0] lenLimit(input logic [1:0] s);
    case (s)
      2'd0:    return 16'hFFFF;
      2'd1:    return 16'h0FFF;
      2'd2:    return 16'h03FF;
      default: return 16'h00FF;
    endcase
  endfunction

  function automatic logic [CW-1:0] mRead(input logic [AW-1:0] a);
    if (a == 0) return {10'b0, mOvf, mOvfIe, mLen, mMode};
    if (a == 1) return mCnt;
    for (int k = 0; k < NCH; k++) begin
      if (a == AW'(2 + 2 * k)) return {12'b0, mFlg[k], mIe[k], mLd[k]};
      if (a == AW'(3 + 2 * k)) return mCmp[k];
    end
    return '0;
  endfunction

  function automatic bit mIrq0();
    return mFlg[0] && mIe[0];
  endfunction

  function automatic bit mIrq1();
    bit r;
    r = mOvf && mOvfIe;
    for (int k = 1; k < NCH; k++) r = r | (mFlg[k] && mIe[k]);
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = '0; mDown = 0; mMode = '0; mLen = '0; mOvfIe = 0; mOvf = 0;
      for (int k = 0; k < NCH; k++) begin
        mCmp[k] = '0; mLat[k] = '0; mLd[k] = '0; mIe[k] = 0; mFlg[k] = 0;
      end
    end else begin : mstep
      logic [CW-1:0] nCnt, lim;
      bit nDown, ovfHit;
      bit hitK [NCH];
      bit ldK  [NCH];
      nCnt = mCnt; nDown = mDown; ovfHit = 0; lim = lenLimit(mLen);
      for (int k = 0; k < NCH; k++) begin hitK[k] = 0; ldK[k] = 0; end
      if (tick && mMode != 0) begin
        if (mMode == 1) begin
          if (mCnt == mLat[0] || mCnt >= lim) begin nCnt = 0; ovfHit = 1; end
          else nCnt = mCnt + 1;
        end else if (mMode == 2) begin
          if (mCnt >= lim) begin nCnt = 0; ovfHit = 1; end
          else nCnt = mCnt + 1;
        end else begin
          if (mCnt >= mLat[0] || mCnt >= lim) nDown = 1;
          if (mCnt == 0) nDown = 0;
          if (nDown) begin nCnt = mCnt - 1; if (mCnt == 1) ovfHit = 1; end
          else nCnt = mCnt + 1;
        end
        for (int k = 0; k < NCH; k++) begin
          hitK[k] = (mCnt == mLat[k]);
          case (mLd[k])
            2'd1:    ldK[k] = (mCnt == 0);
            2'd2:    ldK[k] = (mCnt == 0) || (mMode == 3 && hitK[k]);
            2'd3:    ldK[k] = hitK[k];
            default: ldK[k] = 0;
          endcase
        end
      end
      for (int k = 0; k < NCH; k++) if (ldK[k]) mLat[k] = mCmp[k];
      if (wrEn) begin
        if (wrAddr == 0) begin
          mMode = wrData[1:0]; mLen = wrData[3:2]; mOvfIe = wrData[4];
          mOvf = mOvf & wrData[5];
        end else if (wrAddr == 1) begin
          nCnt = wrData;
        end else begin
          for (int k = 0; k < NCH; k++) begin
            if (wrAddr == AW'(2 + 2 * k)) begin
              mLd[k] = wrData[1:0]; mIe[k] = wrData[2];
              mFlg[k] = mFlg[k] & wrData[3];
            end
            if (wrAddr == AW'(3 + 2 * k)) begin
              mCmp[k] = wrData;
              if (mLd[k] == 0) mLat[k] = wrData;
            end
          end
        end
      end
      mOvf = mOvf | ovfHit;
      for (int k = 0; k < NCH; k++) mFlg[k] = mFlg[k] | hitK[k];
      mCnt = nCnt; mDown = nDown;
    end
  end

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R12 readback vs model", rdData, mRead(rdAddr));
      check("R11 irq0 vs model", CW'(irq0), CW'(mIrq0()));
      check("R11 irq1 vs model", CW'(irq1), CW'(mIrq1()));
    end
  end

  task automatic step(input bit t, input bit w, input int a, input int d);
    @(negedge clk);
    #1;
    tick = t; wrEn = w; wrAddr = AW'(a); wrData = CW'(d);
    @(posedge clk);
    #1;
    tick = 0; wrEn = 0;
  endtask

  task automatic wr(input int a, input int d);
    step(0, 1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask

  task automatic peek(input int a, input int exp, input string tag);
    rdAddr = AW'(a);
    #1;
    check(tag, rdData, CW'(exp));
  endtask

  task automatic peekIrq(input bit e0, input bit e1, input string tag);
    check({tag, " irq0"}, CW'(irq0), CW'(e0));
    check({tag, " irq1"}, CW'(irq1), CW'(e1));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    doReset();
    for (int a = 0; a < 16; a++) peek(a, 0, "R1 reset value");
    peekIrq(0, 0, "R1 reset");

    // R2: immediate load in mode 0
    wr(0, 1);
    wr(3, 3);
    ticks(2);
    wr(3, 10);
    ticks(2);
    peek(1, 4, "R2 period moved at once");

    // R3: load at zero, R6 up wrap, R11, R12
    doReset();
    wr(4, 4); wr(5, 16'hFF); wr(4, 5);
    wr(3, 6);
    wr(0, 1);
    ticks(3);
    wr(5, 4);
    peek(5, 4, "R12 compare reads register");
    ticks(2);
    peek(4, 5, "R3 no load before zero");
    ticks(7);
    peek(4, 13, "R3 loaded at zero");
    peek(1, 5, "R6 wrapped count");
    peek(0, 16'h21, "R6 overflow flag");
    peekIrq(0, 1, "R11 channel flag");

    // R4: mode 2 in up/down, R7
    doReset();
    wr(3, 10);
    wr(8, 4); wr(9, 5); wr(8, 6);
    wr(0, 3);
    ticks(4);
    wr(9, 8);
    ticks(2);
    peek(8, 14, "R4 match at old latch");
    wr(8, 6);
    ticks(3);
    peek(8, 14, "R4 new latch used");
    ticks(2);
    peek(1, 9, "R7 turned down");
    ticks(9);
    peek(1, 0, "R7 reached zero");
    peek(0, 16'h23, "R7 overflow at bottom");
    ticks(1);
    peek(1, 1, "R7 turned up");

    // R5: load on own match
    doReset();
    wr(3, 10);
    wr(6, 4); wr(7, 5); wr(6, 7);
    wr(0, 1);
    ticks(4);
    wr(7, 8);
    ticks(2);
    wr(7, 2);
    peek(6, 15, "R5 first match");
    wr(6, 7);
    ticks(3);
    peek(6, 15, "R5 second latch");
    wr(6, 7);
    ticks(5);
    peek(6, 15, "R5 third latch");

    // R8: continuous lengths
    for (int s = 0; s < 4; s++) begin
      int lim;
      lim = (s == 0) ? 16'hFFFF : (s == 1) ? 16'h0FFF : (s == 2) ? 16'h03FF : 16'h00FF;
      doReset();
      wr(0, 2 | (s << 2));
      wr(1, lim - 1);
      ticks(1);
      peek(1, lim, "R8 at limit");
      ticks(1);
      peek(1, 0, "R8 wrapped");
      peek(0, 16'h20 | 2 | (s << 2), "R8 overflow flag");
    end

    // R9: stop mode freezes
    doReset();
    wr(3, 5);
    wr(1, 5);
    ticks(3);
    peek(1, 5, "R9 stopped count");
    peek(2, 0, "R9 no flag while stopped");

    // R10 flag rules, R11 irq composition
    doReset();
    wr(3, 3); wr(2, 4); wr(0, 1);
    ticks(4);
    peek(2, 12, "R10 flag set");
    peekIrq(1, 0, "R11 ovf without enable");
    wr(2, 12);
    peek(2, 12, "R10 write 1 keeps");
    wr(2, 4);
    peek(2, 4, "R10 write 0 clears");
    peekIrq(0, 0, "R10 after clear");
    ticks(3);
    step(1, 1, 2, 4);
    peek(2, 12, "R10 set wins over clear");
    wr(0, 16'h31);
    peek(0, 16'h31, "R11 overflow enable");
    peekIrq(1, 1, "R11 overflow enabled");
    wr(0, 16'h11);
    peekIrq(1, 0, "R11 overflow cleared");

    // mixed stimulus against the model
    doReset();
    for (int i = 0; i < 3000; i++) begin
      int a, d;
      a = $urandom_range(0, 15);
      if (a == 0)      d = $urandom_range(0, 63);
      else if (a == 1) d = $urandom_range(0, 40);
      else if (a[0])   d = $urandom_range(0, 30);
      else             d = $urandom_range(0, 15);
      rdAddr = AW'($urandom_range(0, 15));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, a, d);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule